// File: doc/BRIEF.md
# Sub-word access adapter

This adapter connects a bus master that issues byte, halfword and word accesses to a register block that only takes aligned 32-bit reads and writes. A narrow read becomes one word read. The word that comes back is shifted down so that the addressed byte lane sits at bit 0. A narrow write is handled in one of three ways, chosen by a per-word class taken from a table parameter:

- **Ordinary storage registers** get a read, merge and write sequence.
- **Action registers** (set, clear and write-one-to-clear aliases) get the shifted data written straight through. No read is done first, so the bytes outside the lane are sent as zero and trigger nothing.
- **Read-only words** ignore the write.

Full-word accesses go through untouched. Words that the table does not classify take no part in any access.

The register block must return read data combinationally, in the same cycle as it sees a read. The read-merge-write sequence takes two downstream cycles. While the write half of that sequence runs, the adapter drops its upstream ready.

Top module: `subword_access_adapter`

## Requirements
- R1: After reset, `up_ready` is 1, and `up_rvalid` and `dn_valid` are 0.
- R2: Every downstream access uses the upstream address with its two low bits forced to zero.
- R3: A narrow read (`up_size` 0 = byte, 1 = halfword) of a classified word returns that word shifted right by 8 × `up_addr[1:0]`. The upper bits are not masked.
- R4: A narrow write to a storage word (class code 1) first reads the word. It then clears a 16-bit window that starts at bit 8 × `up_addr[1:0]`, clipped at bit 31. Finally it ORs in the lane data shifted by the same amount, and writes the result back. The lane data is `up_wdata[7:0]` for a byte and `up_wdata[15:0]` for a halfword.
- R5: The sequence in R4 makes exactly one downstream read, in the accept cycle, and one downstream write in the next cycle. During that write cycle `up_ready` is 0. It returns to 1 one cycle later.
- R6: A narrow write to an action word (class code 2) makes exactly one downstream write with the shifted lane data and zeros elsewhere. It makes no read, and `up_ready` stays 1.
- R7: A narrow write to a read-only word (class code 3) makes no downstream access, and the word is unchanged.
- R8: A word access (`up_size` 2 or 3) to any classified word passes through as a single access, whatever the class and whatever `up_addr[1:0]` is. A word read returns the word unshifted.
- R9: A word is unclassified when its class code is 0, or when its index `up_addr[11:2]` is at or above the table size. Writes to an unclassified word are dropped, and reads return 0 with no downstream access.
- R10: `up_rvalid` is 1 for one cycle, the cycle after each accepted read. An accepted write never raises it.
- R11: The class of word index i is bits [2i+1:2i] of the table parameter. In the default table, index 0 is storage, index 2 is action, index 3 is read-only, index 6 is unclassified, and there are 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream request present |
| up_ready | output | 1 | Adapter can accept a request this cycle |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Byte address |
| up_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| up_wdata | input | DATA_W | Write data, lane data in the low bits for narrow writes |
| up_rvalid | output | 1 | Read data valid |
| up_rdata | output | DATA_W | Read data, lane-aligned for narrow reads |
| dn_valid | output | 1 | Downstream access this cycle |
| dn_write | output | 1 | Downstream access is a write |
| dn_addr | output | ADDR_W | Word-aligned downstream address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rdata | input | DATA_W | Downstream read data, combinational with the read |

## Verification
The hardest situations to reach from the ports are those where the adapter must do nothing at all. A narrow write to a read-only or unclassified word leaves no trace on the upstream side. A wrong merge window only shows when the neighbouring bytes hold known, distinct values.

The bench models the register block as a word array that counts downstream reads and writes. Before every narrow write it preloads the target word with a full-word write carrying a distinct pattern. It then sweeps every word index up to one past the table, both narrow sizes and all four lanes, including the lanes where the 16-bit window spills into the next byte or is clipped at the top. After each access it compares the stored word and the access counts with values computed from the requirements.

// File: rtl/sw_adapt_pkg.sv
// Package: shared types for the sub-word access adapter.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package sw_adapt_pkg;

    // Per-word behaviour class, two bits per entry in the class table.
    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_PLAIN  = 2'd1,
        CLS_ACTION = 2'd2,
        CLS_RDONLY = 2'd3
    } reg_class_e;

    // Upstream access size codes.
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Sequencer state.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RMW_WR = 1'b1
    } seq_state_e;

endpackage

// File: rtl/sw_class_lookup.sv
// Module: sw_class_lookup
// Maps a word index onto its behaviour class using a packed table parameter.
// Assumes: the table holds NUM_REGS two-bit entries, and entry i belongs to
// word index i. Any index at or above NUM_REGS is unclassified.
module sw_class_lookup
    import sw_adapt_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int NUM_REGS = 8,
    parameter logic [2*NUM_REGS-1:0] CLASS_MAP = '0
) (
    input  logic [IDX_W-1:0] word_idx,
    output reg_class_e       cls
);

    logic [NUM_REGS-1:0] hit;
    logic [1:0]          entry [NUM_REGS];

    // One comparator and one table slice per classified word.
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_entry
        assign hit[gi]   = (word_idx == IDX_W'(gi));
        assign entry[gi] = CLASS_MAP[2*gi +: 2];
    end

    // OR together the entry of the single matching word, if any.
    always_comb begin
        logic [1:0] acc;
        acc = 2'd0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) acc = acc | entry[i];
        end
        cls = reg_class_e'(acc);
    end

endmodule

// File: rtl/sw_lane_align.sv
// Module: sw_lane_align
// Lane datapath: shifts narrow read data down, shifts narrow write data up,
// and forms the merged word for a read-merge-write.
// Assumes: DATA_W is a multiple of 8 and a power of two, and WIN_W < 64.
module sw_lane_align
    import sw_adapt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WIN_W  = 16
) (
    input  logic [1:0]             size,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [DATA_W-1:0]      dn_word,
    output logic                   narrow,
    output logic [DATA_W-1:0]      rd_shifted,
    output logic [DATA_W-1:0]      wr_direct,
    output logic [DATA_W-1:0]      wr_merged
);

    localparam int LANE_W = $clog2(DATA_W/8);
    localparam int SH_W   = LANE_W + 3;
    localparam logic [DATA_W-1:0] WIN_BASE = DATA_W'((64'd1 << WIN_W) - 64'd1);

    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] win;

    // Decode the access size and the bit offset of the lane.
    always_comb begin
        narrow = (size == SZ_BYTE) || (size == SZ_HALF);
        sh     = {lane, 3'b000};
    end

    // Keep only the bytes that the access size covers.
    always_comb begin
        if (size == SZ_BYTE) lane_data = DATA_W'(wdata[7:0]);
        else                 lane_data = DATA_W'(wdata[15:0]);
    end

    // Data that is written without read-back, and the data returned on a read.
    always_comb begin
        wr_direct  = narrow ? (lane_data << sh) : wdata;
        rd_shifted = narrow ? (dn_word >> sh) : dn_word;
    end

    // Clear the fixed-width window at the lane, then insert the new lane data.
    always_comb begin
        win       = WIN_BASE << sh;
        wr_merged = (dn_word & ~win) | (lane_data << sh);
    end

endmodule

// File: rtl/sw_access_seq.sv
// Module: sw_access_seq
// Sequencer: decides per request whether to read, write, read-merge-write or
// drop, drives the downstream port, and returns read data one cycle later.
// Assumes: downstream read data is valid in the same cycle as the read.
module sw_access_seq
    import sw_adapt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              narrow,
    input  reg_class_e        cls,
    input  logic [DATA_W-1:0] wr_direct,
    input  logic [DATA_W-1:0] wr_merged,
    input  logic [DATA_W-1:0] rd_shifted,
    output logic              up_ready,
    output logic              up_rvalid,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata
);

    localparam int LANE_W = $clog2(DATA_W/8);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [DATA_W-1:0] hold_data_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept;
    logic              go_rmw;

    // Accept only while idle; the write half of a merge stalls the bus.
    always_comb begin
        up_ready = (state_q == ST_IDLE);
        accept   = up_valid && up_ready;
    end

    // Choose the downstream access for this cycle.
    always_comb begin
        dn_valid = 1'b0;
        dn_write = 1'b0;
        dn_addr  = {up_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        dn_wdata = wr_direct;
        go_rmw   = 1'b0;
        if (state_q == ST_RMW_WR) begin
            dn_valid = 1'b1;
            dn_write = 1'b1;
            dn_addr  = hold_addr_q;
            dn_wdata = hold_data_q;
        end else if (accept && (cls != CLS_NONE)) begin
            if (!up_write) begin
                dn_valid = 1'b1;
            end else if (!narrow) begin
                dn_valid = 1'b1;
                dn_write = 1'b1;
            end else begin
                case (cls)
                    CLS_PLAIN: begin
                        dn_valid = 1'b1;
                        go_rmw   = 1'b1;
                    end
                    CLS_ACTION: begin
                        dn_valid = 1'b1;
                        dn_write = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // State, merge holding registers and the registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            hold_addr_q <= '0;
            hold_data_q <= '0;
            rvalid_q    <= 1'b0;
            rdata_q     <= '0;
        end else begin
            state_q  <= go_rmw ? ST_RMW_WR : ST_IDLE;
            rvalid_q <= accept && !up_write;
            if (go_rmw) begin
                hold_addr_q <= dn_addr;
                hold_data_q <= wr_merged;
            end
            if (accept && !up_write) begin
                rdata_q <= (cls == CLS_NONE) ? '0 : rd_shifted;
            end
        end
    end

    assign up_rvalid = rvalid_q;
    assign up_rdata  = rdata_q;

    // R5: the write half follows the read at once, to the same word, with the bus stalled.
    assert_rmw_second_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go_rmw |=> (dn_valid && dn_write && !up_ready && dn_addr == $past(dn_addr)));

    // R5: a stall only ever covers a downstream write.
    assert_stall_only_writing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !up_ready |-> (dn_valid && dn_write));

    // R5: never two stall cycles in a row.
    assert_stall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !up_ready |=> up_ready);

    // R10: read data is reported only after an accepted read.
    assert_rvalid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |-> $past(up_valid && up_ready && !up_write));

endmodule

// File: rtl/subword_access_adapter.sv
// Module: subword_access_adapter
// Top level: joins the class lookup, the lane datapath and the sequencer.
// Assumes: byte addressing, and a word-only register block behind dn_*
// that answers reads in the same cycle.
module subword_access_adapter
    import sw_adapt_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int WIN_W    = 16,
    parameter logic [2*NUM_REGS-1:0] CLASS_MAP = 16'h49E5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [1:0]        up_size,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_rvalid,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata
);

    localparam int LANE_W = $clog2(DATA_W/8);
    localparam int IDX_W  = ADDR_W - LANE_W;

    reg_class_e        cls;
    logic              narrow;
    logic [DATA_W-1:0] rd_shifted;
    logic [DATA_W-1:0] wr_direct;
    logic [DATA_W-1:0] wr_merged;

    sw_class_lookup #(
        .IDX_W     (IDX_W),
        .NUM_REGS  (NUM_REGS),
        .CLASS_MAP (CLASS_MAP)
    ) u_lookup (
        .word_idx (up_addr[ADDR_W-1:LANE_W]),
        .cls      (cls)
    );

    sw_lane_align #(
        .DATA_W (DATA_W),
        .WIN_W  (WIN_W)
    ) u_lane (
        .size       (up_size),
        .lane       (up_addr[LANE_W-1:0]),
        .wdata      (up_wdata),
        .dn_word    (dn_rdata),
        .narrow     (narrow),
        .rd_shifted (rd_shifted),
        .wr_direct  (wr_direct),
        .wr_merged  (wr_merged)
    );

    sw_access_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid   (up_valid),
        .up_write   (up_write),
        .up_addr    (up_addr),
        .narrow     (narrow),
        .cls        (cls),
        .wr_direct  (wr_direct),
        .wr_merged  (wr_merged),
        .rd_shifted (rd_shifted),
        .up_ready   (up_ready),
        .up_rvalid  (up_rvalid),
        .up_rdata   (up_rdata),
        .dn_valid   (dn_valid),
        .dn_write   (dn_write),
        .dn_addr    (dn_addr),
        .dn_wdata   (dn_wdata)
    );

    // R9: an unclassified word never reaches the register block.
    assert_unclassified_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && cls == CLS_NONE) |-> !dn_valid);

    // R7: narrow writes to read-only words are dropped.
    assert_rdonly_narrow_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && up_write && narrow && cls == CLS_RDONLY) |-> !dn_valid);

    // R6: narrow writes to action words go out at once as writes, with no stall after.
    assert_action_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && up_write && narrow && cls == CLS_ACTION)
            |-> (dn_valid && dn_write) ##1 up_ready);

    // R8: word accesses never cause a stall.
    assert_word_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && !narrow) |=> up_ready);

endmodule

// File: tb/sim_subword_access_adapter.sv
// Bench: drives the adapter against a counting word-array model of the
// register block and sweeps words, sizes and lanes.
module sim_subword_access_adapter;

    localparam logic [15:0] MAP = 16'h49E5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic        up_write = 1'b0;
    logic [11:0] up_addr = '0;
    logic [1:0]  up_size = '0;
    logic [31:0] up_wdata = '0;
    logic        up_rvalid;
    logic [31:0] up_rdata;
    logic        dn_valid;
    logic        dn_write;
    logic [11:0] dn_addr;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata;

    logic [31:0] mem [16];
    int          n_rd = 0;
    int          n_wr = 0;
    logic [11:0] last_wr_addr = '0;
    int          tests = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    subword_access_adapter #(
        .ADDR_W(12), .DATA_W(32), .NUM_REGS(8), .WIN_W(16), .CLASS_MAP(MAP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
        .up_write(up_write), .up_addr(up_addr), .up_size(up_size),
        .up_wdata(up_wdata), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    // Register block model: combinational read, counted accesses.
    assign dn_rdata = mem[dn_addr[5:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) mem[k] <= '0;
        end else if (dn_valid) begin
            if (dn_write) begin
                mem[dn_addr[5:2]] <= dn_wdata;
                last_wr_addr <= dn_addr;
                n_wr++;
            end else begin
                n_rd++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int cls_of(input int idx);
        if (idx >= 8) return 0;
        return int'(MAP[2*idx +: 2]);
    endfunction

    // Present one request and return at the negedge after it is accepted.
    task automatic issue(input bit wr, input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        up_valid = 1'b1; up_write = wr; up_addr = a; up_size = sz; up_wdata = d;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(up_ready == 1'b1, "R1 ready", 32'(up_ready), 32'd1);
        chk(up_rvalid == 1'b0, "R1 rvalid", 32'(up_rvalid), 32'd0);
        chk(dn_valid == 1'b0, "R1 dn_valid", 32'(dn_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int idx = 0; idx < 9; idx++) begin
            for (int sz = 0; sz < 2; sz++) begin
                for (int lane = 0; lane < 4; lane++) begin
                    int          c;
                    int          rd0;
                    int          wr0;
                    int          sh;
                    logic [31:0] pat;
                    logic [31:0] d;
                    logic [31:0] ld;
                    logic [31:0] shv;
                    logic [31:0] win;
                    logic [31:0] old;
                    logic [31:0] exp;
                    logic        rdy_after;
                    c   = cls_of(idx);
                    sh  = lane * 8;
                    pat = 32'h9E3779B9 * (idx + 1) ^ (32'h01010101 * (sz * 4 + lane + 1));
                    d   = 32'hC3D2E1F0 ^ (pat >> 3);

                    // Preload with a word write; R8 passes it for every class, R9 drops it.
                    wr0 = n_wr;
                    issue(1'b1, 12'(idx * 4), 2'd2, pat);
                    repeat (2) @(negedge clk);
                    old = (c == 0) ? 32'h0 : pat;
                    if (c == 0) chk(mem[idx] == 32'h0, "R9 word write dropped", mem[idx], 32'h0);
                    else        chk(mem[idx] == pat, "R8 word write pass", mem[idx], pat);

                    // Narrow write.
                    rd0 = n_rd; wr0 = n_wr;
                    ld  = (sz == 0) ? (d & 32'hFF) : (d & 32'hFFFF);
                    shv = ld << sh;
                    win = 32'hFFFF << sh;
                    issue(1'b1, 12'(idx * 4 + lane), 2'(sz), d);
                    rdy_after = up_ready;
                    chk(up_rvalid == 1'b0, "R10 no rvalid on write", 32'(up_rvalid), 32'd0);
                    repeat (2) @(negedge clk);
                    case (c)
                        1: begin
                            exp = (old & ~win) | shv;
                            chk(mem[idx] == exp, "R4 merged word", mem[idx], exp);
                            chk(rdy_after == 1'b0, "R5 stall during write", 32'(rdy_after), 32'd0);
                            chk(n_rd - rd0 == 1, "R5 one read", 32'(n_rd - rd0), 32'd1);
                            chk(n_wr - wr0 == 1, "R5 one write", 32'(n_wr - wr0), 32'd1);
                            chk(last_wr_addr == 12'(idx * 4), "R2 aligned address", 32'(last_wr_addr), 32'(idx * 4));
                        end
                        2: begin
                            exp = shv;
                            chk(mem[idx] == exp, "R6 direct word", mem[idx], exp);
                            chk(rdy_after == 1'b1, "R6 no stall", 32'(rdy_after), 32'd1);
                            chk(n_rd - rd0 == 0, "R6 no read", 32'(n_rd - rd0), 32'd0);
                            chk(n_wr - wr0 == 1, "R6 one write", 32'(n_wr - wr0), 32'd1);
                            chk(last_wr_addr == 12'(idx * 4), "R2 aligned address", 32'(last_wr_addr), 32'(idx * 4));
                        end
                        3: begin
                            exp = old;
                            chk(mem[idx] == exp, "R7 unchanged", mem[idx], exp);
                            chk((n_rd - rd0) + (n_wr - wr0) == 0, "R7 no access", 32'((n_rd - rd0) + (n_wr - wr0)), 32'd0);
                        end
                        default: begin
                            exp = 32'h0;
                            chk(mem[idx] == exp, "R9 unchanged", mem[idx], exp);
                            chk((n_rd - rd0) + (n_wr - wr0) == 0, "R9 no access", 32'((n_rd - rd0) + (n_wr - wr0)), 32'd0);
                        end
                    endcase

                    // Narrow read of the same lane.
                    rd0 = n_rd;
                    issue(1'b0, 12'(idx * 4 + lane), 2'(sz), 32'h0);
                    chk(up_rvalid == 1'b1, "R10 rvalid after read", 32'(up_rvalid), 32'd1);
                    if (c == 0) begin
                        chk(up_rdata == 32'h0, "R9 read zero", up_rdata, 32'h0);
                        chk(n_rd - rd0 == 0, "R9 no read", 32'(n_rd - rd0), 32'd0);
                    end else begin
                        chk(up_rdata == (exp >> sh), "R3 shifted read", up_rdata, exp >> sh);
                        chk(n_rd - rd0 == 1, "R3 one read", 32'(n_rd - rd0), 32'd1);
                    end
                    @(negedge clk);
                    chk(up_rvalid == 1'b0, "R10 single pulse", 32'(up_rvalid), 32'd0);
                end
            end
        end

        // R8: word read with nonzero low address bits returns the word unshifted.
        issue(1'b1, 12'h004, 2'd3, 32'h12345678);
        repeat (2) @(negedge clk);
        issue(1'b0, 12'h007, 2'd2, 32'h0);
        chk(up_rdata == 32'h12345678, "R8 word read unshifted", up_rdata, 32'h12345678);

        // R11: table indices beyond the table are unclassified even with high address bits set.
        issue(1'b0, 12'h404, 2'd2, 32'h0);
        chk(up_rdata == 32'h0, "R11 out-of-table read zero", up_rdata, 32'h0);

        // R10: back-to-back reads give one pulse each.
        @(negedge clk);
        up_valid = 1'b1; up_write = 1'b0; up_addr = 12'h004; up_size = 2'd0;
        @(negedge clk);
        chk(up_rvalid == 1'b1, "R10 first of pair", 32'(up_rvalid), 32'd1);
        up_addr = 12'h005;
        @(negedge clk);
        up_valid = 1'b0;
        chk(up_rvalid == 1'b1 && up_rdata == 32'h00123456, "R10 second of pair", up_rdata, 32'h00123456);
        @(negedge clk);
        chk(up_rvalid == 1'b0, "R10 pair ends", 32'(up_rvalid), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule